// File: doc/BRIEF.md
# Interleaved Bitplane Pixel Serializer

This block sits between the video fetch path and the palette lookup of a display pipeline. Video memory stores each group of eight neighbouring pixels as a run of bytes, one byte per bitplane, where bit 7 of every byte belongs to the leftmost pixel. The fetch logic hands the block those bytes one at a time, each tagged with its plane number. The block gathers them in a bank of holding registers. Once a whole group is present, the group moves into one shift register per plane.

On each pixel-clock enable, every plane register shifts left by one position. The top bit of each register forms one bit of the palette index, with plane 0 as the least significant bit. The number of active planes can be set from one to four, which gives 2, 4, 8 or 16 colours. Index bits for planes above the active count are forced to zero.

The next group is held back until the current eight pixels have been shown. It then moves into the shift registers on the enable that begins it, so consecutive groups follow one another without a gap. If no complete group is waiting at that point, the valid output drops and the index reads zero until a group arrives.

Top module: `bitplane_serializer`

## Requirements
- R1: After reset, `pix_valid_o` is 0 and `pix_idx_o` is 0.
- R2: Loading plane bytes without any `pix_en_i` pulse leaves `pix_valid_o` at 0 and `pix_idx_o` at 0.
- R3: When a complete group is waiting and no pixels are left from the previous group, a `pix_en_i` pulse transfers the group. In the following cycle `pix_valid_o` is 1 and `pix_idx_o` bit p equals bit 7 of the byte loaded for plane p (plane 0 = index bit 0).
- R4: Each later `pix_en_i` pulse within a group advances one pixel: the k-th pixel of a group (k = 0..7) shows bit 7-k of each plane byte.
- R5: In cycles without `pix_en_i`, `pix_idx_o` and `pix_valid_o` stay unchanged.
- R6: Index bits at positions equal to or above the effective plane count are 0.
- R7: A load whose plane number is equal to or above the effective plane count is ignored: it stores nothing and does not complete a group.
- R8: A group counts as complete only when the plane numbered (effective count - 1) has been loaded. Loading lower planes alone does not start output.
- R9: A group loaded while the previous group is still being shown appears on the `pix_en_i` pulse that follows the previous group's eighth pixel, with `pix_valid_o` staying 1.
- R10: If the eighth pixel of a group is followed by a `pix_en_i` pulse while no complete group is waiting, `pix_valid_o` goes to 0 and `pix_idx_o` to 0. Output resumes on a later pulse once a group is complete.
- R11: A plane-count value of 0 acts as 1, and values above 4 act as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_i | input | 8 | Plane byte from video memory |
| load_i | input | 1 | Store `data_i` into the holding register of `plane_i` |
| plane_i | input | 2 | Plane number of the byte being loaded |
| planes_i | input | 3 | Number of active bitplanes (1..4) |
| pix_en_i | input | 1 | Pixel-clock enable, one pixel per pulse |
| pix_idx_o | output | 4 | Palette index of the current pixel |
| pix_valid_o | output | 1 | Current pixel comes from a transferred group |

## Verification
A holding register that captures a byte for the wrong plane, or a ready flag raised too early, appears at the very next group transfer. It shows up either as a wrong index bit on the first pixel of that group or as `pix_valid_o` rising when it should not. A shift register that moves on the wrong enable, or a pixel counter that is off by one, corrupts the bit order within at most eight `pix_en_i` pulses. It also moves the group boundary, so the seamless-handover and underrun checks fail on the pulse right after the eighth pixel. The masking of unused planes is checked by leaving non-zero stale bytes in those holding registers and then changing the plane count.

// File: rtl/bps_pkg.sv
package bps_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Map a raw plane-count setting onto 1..max_planes.
    function automatic int unsigned clamp_count(int unsigned raw, int unsigned max_planes);
        if (raw == 0) begin
            return 1;
        end else if (raw > max_planes) begin
            return max_planes;
        end
        return raw;
    endfunction

endpackage

// File: rtl/bps_plane_latch.sv
module bps_plane_latch #(
    parameter int unsigned MAX_PLANES = 4,
    parameter int unsigned DATA_W     = 8,
    localparam int unsigned PL_W      = (MAX_PLANES > 1) ? $clog2(MAX_PLANES) : 1,
    localparam int unsigned CNT_W     = $clog2(MAX_PLANES + 1)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               load_i,
    input  logic [PL_W-1:0]                    plane_i,
    input  logic [DATA_W-1:0]                  data_i,
    input  logic [CNT_W-1:0]                   cnt_i,
    input  logic                               xfer_i,
    output logic [MAX_PLANES-1:0][DATA_W-1:0]  hold_o,
    output logic                               ready_o
);

    typedef struct packed {
        logic [MAX_PLANES-1:0][DATA_W-1:0] bytes;
        logic                              ready;
    } latch_st_t;

    latch_st_t st_d, st_q;

    logic [CNT_W-1:0] plane_ext;
    logic             plane_ok;
    logic             plane_last;

    always_comb begin
        plane_ext  = CNT_W'(plane_i);
        plane_ok   = plane_ext < cnt_i;
        plane_last = (plane_ext + CNT_W'(1)) == cnt_i;

        st_d = st_q;
        if (xfer_i) begin
            st_d.ready = 1'b0;
        end
        if (load_i && plane_ok) begin
            st_d.bytes[plane_i] = data_i;
            if (plane_last) begin
                st_d.ready = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o  = st_q.bytes;
    assign ready_o = st_q.ready;

    // R8
    ready_needs_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ready && !(load_i && plane_last)) |=> !st_q.ready);

    for (genvar g = 0; g < MAX_PLANES; g++) begin : g_ign
        // R7
        ignored_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (load_i && plane_i == PL_W'(g) && CNT_W'(g) >= cnt_i)
            |=> $stable(st_q.bytes[g]));
    end

endmodule

// File: rtl/bps_plane_shift.sv
module bps_plane_shift #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              msb_o
);

    typedef struct packed {
        logic [DATA_W-1:0] bits;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.bits = data_i;
        end else if (shift_i) begin
            st_d.bits = {st_q.bits[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msb_o = st_q.bits[DATA_W-1];

    // R3
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> st_q.bits == $past(data_i));

    // R4
    shift_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> st_q.bits[DATA_W-1:1] == $past(st_q.bits[DATA_W-2:0]) && !st_q.bits[0]);

endmodule

// File: rtl/bps_pixel_seq.sv
module bps_pixel_seq #(
    parameter int unsigned PIX_PER_GROUP = 8,
    localparam int unsigned PC_W         = $clog2(PIX_PER_GROUP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pix_en_i,
    input  logic ready_i,
    output logic xfer_o,
    output logic shift_o,
    output logic active_o
);

    import bps_pkg::*;

    typedef struct packed {
        seq_state_e      state;
        logic [PC_W-1:0] left;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic group_done;

    always_comb begin
        group_done = (st_q.state == SEQ_IDLE) || (st_q.left == PC_W'(1));
        xfer_o     = pix_en_i && group_done && ready_i;
        shift_o    = pix_en_i && !group_done;

        st_d = st_q;
        if (xfer_o) begin
            st_d.state = SEQ_RUN;
            st_d.left  = PC_W'(PIX_PER_GROUP);
        end else if (shift_o) begin
            st_d.left  = st_q.left - PC_W'(1);
        end else if (pix_en_i) begin
            st_d.state = SEQ_IDLE;
            st_d.left  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: SEQ_IDLE, left: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = (st_q.state == SEQ_RUN);

    // R3
    xfer_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en_i && ready_i && group_done) |=> active_o && st_q.left == PC_W'(PIX_PER_GROUP));

    // R5
    hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en_i |=> $stable(st_q.state) && $stable(st_q.left));

    // R10
    underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en_i && group_done && !ready_i) |=> !active_o);

    left_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> (st_q.left != '0 && st_q.left <= PC_W'(PIX_PER_GROUP)));

endmodule

// File: rtl/bitplane_serializer.sv
module bitplane_serializer #(
    parameter int unsigned MAX_PLANES = 4,
    parameter int unsigned DATA_W     = 8,
    localparam int unsigned PL_W      = (MAX_PLANES > 1) ? $clog2(MAX_PLANES) : 1,
    localparam int unsigned CNT_W     = $clog2(MAX_PLANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DATA_W-1:0]     data_i,
    input  logic                  load_i,
    input  logic [PL_W-1:0]       plane_i,
    input  logic [CNT_W-1:0]      planes_i,
    input  logic                  pix_en_i,
    output logic [MAX_PLANES-1:0] pix_idx_o,
    output logic                  pix_valid_o
);

    logic [CNT_W-1:0]                  eff_cnt;
    logic [MAX_PLANES-1:0][DATA_W-1:0] hold;
    logic                              ready;
    logic                              xfer;
    logic                              shift;
    logic                              active;
    logic [MAX_PLANES-1:0]             msb;

    always_comb begin
        eff_cnt = CNT_W'(bps_pkg::clamp_count(int'(planes_i), MAX_PLANES));
    end

    bps_plane_latch #(
        .MAX_PLANES (MAX_PLANES),
        .DATA_W     (DATA_W)
    ) latch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .plane_i (plane_i),
        .data_i  (data_i),
        .cnt_i   (eff_cnt),
        .xfer_i  (xfer),
        .hold_o  (hold),
        .ready_o (ready)
    );

    bps_pixel_seq #(
        .PIX_PER_GROUP (DATA_W)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_en_i (pix_en_i),
        .ready_i  (ready),
        .xfer_o   (xfer),
        .shift_o  (shift),
        .active_o (active)
    );

    for (genvar p = 0; p < MAX_PLANES; p++) begin : g_plane
        bps_plane_shift #(
            .DATA_W (DATA_W)
        ) shift_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (xfer),
            .shift_i (shift),
            .data_i  (hold[p]),
            .msb_o   (msb[p])
        );
    end

    always_comb begin
        pix_valid_o = active;
        for (int p = 0; p < MAX_PLANES; p++) begin
            pix_idx_o[p] = active && (CNT_W'(p) < eff_cnt) && msb[p];
        end
    end

    // R6
    upper_planes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_idx_o >> eff_cnt) == '0);

    // R10
    idle_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_o |-> pix_idx_o == '0);

    // R3
    xfer_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_valid_o && !(pix_en_i && ready)) |=> !pix_valid_o);

endmodule

// File: tb/bitplane_serializer_tb_top.sv
module bitplane_serializer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] data_i;
    logic       load_i;
    logic [1:0] plane_i;
    logic [2:0] planes_i;
    logic       pix_en_i;
    logic [3:0] pix_idx_o;
    logic       pix_valid_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    bitplane_serializer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_i      (data_i),
        .load_i      (load_i),
        .plane_i     (plane_i),
        .planes_i    (planes_i),
        .pix_en_i    (pix_en_i),
        .pix_idx_o   (pix_idx_o),
        .pix_valid_o (pix_valid_o)
    );

    // {count[35:32], plane0[31:24], plane1[23:16], plane2[15:8], plane3[7:0]}
    localparam logic [35:0] VEC [6] = '{
        {4'd1, 8'hA5, 8'hFF, 8'hFF, 8'hFF},
        {4'd2, 8'h3C, 8'hF0, 8'h81, 8'h7E},
        {4'd3, 8'h96, 8'h0F, 8'hC3, 8'h55},
        {4'd4, 8'h01, 8'h80, 8'hAA, 8'h5A},
        {4'd4, 8'hFF, 8'h00, 8'hFF, 8'h00},
        {4'd2, 8'h00, 8'h00, 8'h12, 8'h34}
    };

    logic [35:0] ve;

    function automatic logic [3:0] exp_idx(int cnt, logic [31:0] b, int k);
        logic [3:0] r = '0;
        for (int p = 0; p < cnt; p++) begin
            r[p] = b[31 - 8*p - k];
        end
        return r;
    endfunction

    task automatic check(string req, logic [4:0] act, logic [4:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {valid,idx} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_load(int p, logic [7:0] d);
        @(negedge clk);
        load_i  = 1'b1;
        plane_i = 2'(p);
        data_i  = d;
        @(negedge clk);
        load_i  = 1'b0;
    endtask

    task automatic do_pix();
        @(negedge clk);
        pix_en_i = 1'b1;
        @(negedge clk);
        pix_en_i = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        data_i   = '0;
        load_i   = 1'b0;
        plane_i  = '0;
        planes_i = 3'd1;
        pix_en_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {pix_valid_o, pix_idx_o}, 5'b0);

        // Table walk: R2 before the first pulse, R3/R4/R6 per pixel
        for (int v = 0; v < 6; v++) begin
            ve       = VEC[v];
            planes_i = 3'(ve[35:32]);
            for (int p = 0; p < int'(ve[35:32]); p++) begin
                do_load(p, ve[31 - 8*p -: 8]);
            end
            if (v == 0) begin
                repeat (2) @(negedge clk);
                check("R2", {pix_valid_o, pix_idx_o}, 5'b0);
            end
            for (int k = 0; k < 8; k++) begin
                do_pix();
                check(k == 0 ? "R3" : "R4 R6", {pix_valid_o, pix_idx_o},
                      {1'b1, exp_idx(int'(ve[35:32]), ve[31:0], k)});
            end
        end

        // R10: underrun after the eighth pixel
        do_pix();
        check("R10", {pix_valid_o, pix_idx_o}, 5'b0);
        do_pix();
        check("R10", {pix_valid_o, pix_idx_o}, 5'b0);

        // R8: partial group does not start output
        planes_i = 3'd3;
        do_load(0, 8'hFF);
        do_load(1, 8'hFF);
        do_pix();
        check("R8", {pix_valid_o, pix_idx_o}, 5'b0);
        do_load(2, 8'h00);
        do_pix();
        check("R8 R10", {pix_valid_o, pix_idx_o}, 5'b1_0011);

        // R5: no enable, no change
        repeat (3) @(negedge clk);
        check("R5", {pix_valid_o, pix_idx_o}, 5'b1_0011);

        // R9: next group loaded mid-display follows seamlessly
        do_load(0, 8'h00);
        do_load(1, 8'h00);
        do_load(2, 8'hFF);
        for (int k = 1; k < 8; k++) begin
            do_pix();
        end
        check("R9", {pix_valid_o, pix_idx_o}, 5'b1_0011);
        do_pix();
        check("R9", {pix_valid_o, pix_idx_o}, 5'b1_0100);
        for (int k = 1; k < 8; k++) begin
            do_pix();
        end

        // R7: loads to planes above the count are ignored
        planes_i = 3'd4;
        for (int p = 0; p < 4; p++) begin
            do_load(p, 8'h00);
        end
        do_pix();
        check("R7", {pix_valid_o, pix_idx_o}, 5'b1_0000);
        for (int k = 1; k < 8; k++) begin
            do_pix();
        end
        planes_i = 3'd2;
        do_load(3, 8'hFF);
        do_load(2, 8'hFF);
        do_load(0, 8'h80);
        do_load(1, 8'h80);
        planes_i = 3'd4;
        do_pix();
        check("R7", {pix_valid_o, pix_idx_o}, 5'b1_0011);
        for (int k = 1; k < 8; k++) begin
            do_pix();
        end

        // R11: count 0 acts as 1
        planes_i = 3'd0;
        do_load(0, 8'h80);
        do_pix();
        check("R11", {pix_valid_o, pix_idx_o}, 5'b1_0001);
        for (int k = 1; k < 8; k++) begin
            do_pix();
        end
        check("R11", {pix_valid_o, pix_idx_o}, 5'b1_0000);

        // R11: count 7 acts as 4
        planes_i = 3'd7;
        for (int p = 0; p < 4; p++) begin
            do_load(p, 8'h80);
        end
        do_pix();
        check("R11", {pix_valid_o, pix_idx_o}, 5'b1_1111);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule